// File: doc/BRIEF.md
# Dual-Clock Frequency Ratio Calculator

This block turns two accumulated-phase streams into a digital frequency ratio. Both streams count the phase of one shared free-running ring oscillator. The ring's frequency is unknown. One stream is latched on a reference clock of known frequency, and the other on the signal clock being measured. Each channel takes the difference between successive phase samples in its own clock domain. The result is the number of ring phase steps per cycle of that clock: the reference count is f(ring)/f(ref) and the signal count is f(ring)/f(sig). Differencing an accumulated phase also gives the quantization error a first-order high-pass shape.

The signal-domain count crosses into the reference domain through a toggle request/acknowledge register transfer. The reference domain always works with the most recent count that arrived complete. A restoring divider then forms the reference count divided by the signal count, one quotient bit per reference cycle. The ring frequency cancels out, so the output is f(sig)/f(ref) in unsigned fixed point with FRAC_W fractional bits, and 1.0 means the two frequencies are equal. The reference and signal clocks are asynchronous to each other. Each has its own synchronous active-low reset.

Top module: `freq_ratio_calc`

## Requirements
- R1: While a reset is asserted, and on the first cycle after it, `dref_vld`, `dsig_sig_vld`, `fout_vld` and `dsig_have` are 0, and `dref`, `dsig_ref` and `fout` are 0.
- R2: After reset, the first phase sample of a channel only primes that channel. It produces no frequency strobe.
- R3: Every later reference sample presented at clock edge k makes `dref_vld` high for the cycle after edge k. At that time `dref` equals the new sample minus the previous one, modulo 2^PHASE_W.
- R4: Every signal sample after the first gives the same modular difference on `dsig`, with `dsig_sig_vld` high for one signal-clock cycle.
- R5: After a settling window, `dsig_ref` in the reference domain holds the last signal count produced and `dsig_have` is 1. Signal counts that arrive while a transfer is in flight are merged, so the newest one wins. `dsig_ref` changes only on a transfer.
- R6: A division is accepted on the reference edge that sees `dref_vld` high while the divider is idle. `fout_vld` pulses for one cycle after the following PHASE_W+FRAC_W edges, and `fout` = floor(dref * 2^FRAC_W / dsig_ref). `fout` holds its value between pulses.
- R7: When no signal count has arrived since reset, or when `dsig_ref` is 0, a reference count starts no division, and `fout_vld` stays 0.
- R8: A reference count that arrives while the divider is busy, up to and including its final step, is dropped. It changes neither the result in progress nor the number of `fout_vld` pulses.
- R9: A phase counter that wraps between two samples still gives the correct positive difference. For example, samples 65500 and then 200 with PHASE_W = 16 give 236.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (known frequency) |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| sig_clk | input | 1 | Signal clock under measurement |
| sig_rst_n | input | 1 | Synchronous active-low reset, signal domain |
| ref_phase | input | PHASE_W | Total ring phase latched by the reference clock |
| ref_phase_vld | input | 1 | Strobe: `ref_phase` holds a new sample |
| sig_phase | input | PHASE_W | Total ring phase latched by the signal clock |
| sig_phase_vld | input | 1 | Strobe: `sig_phase` holds a new sample |
| dref | output | PHASE_W | Ring phase steps per reference cycle |
| dref_vld | output | 1 | One-cycle strobe for a new `dref` |
| dsig | output | PHASE_W | Ring phase steps per signal cycle (signal domain) |
| dsig_sig_vld | output | 1 | One-cycle strobe for a new `dsig` (signal domain) |
| dsig_ref | output | PHASE_W | Latest signal count as seen in the reference domain |
| dsig_have | output | 1 | A signal count has reached the reference domain since reset |
| fout | output | PHASE_W+FRAC_W | Ratio f(sig)/f(ref), FRAC_W fractional bits |
| fout_vld | output | 1 | One-cycle strobe for a new `fout` |

## Verification
`dref_vld` is due on the cycle after the reference edge that takes a sample. A resulting `fout_vld` is due PHASE_W+FRAC_W+1 cycles after that edge, that is 33 cycles with the default parameters. A reference model in the bench advances on every reference edge from the same inputs, and the bench compares the model with the outputs one nanosecond after each edge. `dsig` is checked on the signal cycle after its sample edge. The clock crossing has no fixed latency, so `dsig_ref` and `dsig_have` are checked only after a settling window of at least twenty reference cycles. Reference samples are held off during that window, so the model never depends on a crossing that is still in flight.

// File: rtl/freq_ratio_pkg.sv
// Package: shared types and width helpers for the frequency ratio calculator.
package freq_ratio_pkg;

    // Divider control state.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Width of the fixed-point quotient: integer part spans a full phase word.
    function automatic int unsigned quot_width(input int unsigned phase_w,
                                               input int unsigned frac_w);
        return phase_w + frac_w;
    endfunction

endpackage

// File: rtl/phase_delta.sv
// Module: phase_delta
// Differentiates a stream of total-phase samples in one clock domain.
// Each sample after the first yields (sample - previous) modulo 2^W,
// i.e. ring phase steps per sampling-clock cycle.
// Assumes: samples arrive as single-cycle strobes; wrap of the phase
// counter between two samples is at most one full turn.
module phase_delta #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_phase,
    input  logic         in_vld,
    output logic [W-1:0] freq,
    output logic         freq_vld
);

    logic [W-1:0] prev_q;
    logic         primed_q;

    // Latch previous sample and emit the modular difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            freq     <= '0;
            freq_vld <= 1'b0;
        end else begin
            freq_vld <= 1'b0;
            if (in_vld) begin
                prev_q   <= in_phase;
                primed_q <= 1'b1;
                if (primed_q) begin
                    freq     <= in_phase - prev_q;
                    freq_vld <= 1'b1;
                end
            end
        end
    end

    // A strobe only follows a sample taken while already primed.
    p_strobe_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freq_vld |-> ($past(in_vld) && $past(primed_q)));

    // Unprimed channel never strobes on the next cycle.
    p_first_primes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |=> !freq_vld);

endmodule

// File: rtl/cdc_sync.sv
// Module: cdc_sync
// Multi-flop synchronizer for a single level signal.
// Assumes: the input is a level that stays stable for several destination
// cycles (toggle-style signalling), STAGES >= 1.
module cdc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            // Shift the level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/word_xfer.sv
// Module: word_xfer
// Moves a data word from a source clock domain to a destination domain
// using a toggle request and toggle acknowledge. Words arriving while a
// transfer is in flight are merged into one pending slot, newest wins.
// Assumes: the two clocks are unrelated; both resets are applied together.
module word_xfer #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_data,
    input  logic         src_vld,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_data,
    output logic         dst_vld,
    output logic         dst_have
);

    logic [W-1:0] pend_q;
    logic         pend_vld_q;
    logic [W-1:0] hold_q;
    logic         req_q;
    logic         ack_sync;
    logic         req_sync;
    logic         seen_q;

    // Source side: keep newest word pending, launch it when the link is idle.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            hold_q     <= '0;
            req_q      <= 1'b0;
        end else if (src_vld) begin
            pend_q     <= src_data;
            pend_vld_q <= 1'b1;
        end else if (pend_vld_q && (ack_sync == req_q)) begin
            hold_q     <= pend_q;
            req_q      <= ~req_q;
            pend_vld_q <= 1'b0;
        end
    end

    cdc_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (seen_q),
        .q     (ack_sync)
    );

    cdc_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (req_q),
        .q     (req_sync)
    );

    // Destination side: on a request edge, copy the held word and acknowledge.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            seen_q   <= 1'b0;
            dst_data <= '0;
            dst_vld  <= 1'b0;
            dst_have <= 1'b0;
        end else begin
            dst_vld <= 1'b0;
            if (req_sync != seen_q) begin
                seen_q   <= req_sync;
                dst_data <= hold_q;
                dst_vld  <= 1'b1;
                dst_have <= 1'b1;
            end
        end
    end

    // Held word is frozen while a request is outstanding.
    p_hold_frozen_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (req_q != ack_sync) |=> $stable(hold_q));

    // Destination word changes only together with its strobe.
    p_dst_stable_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_vld |-> $stable(dst_data));

endmodule

// File: rtl/ratio_divider.sv
// Module: ratio_divider
// Restoring divider: quotient = (num * 2^FRAC_W) / den, one quotient bit
// per cycle, QW = NUM_W + FRAC_W cycles per division.
// Assumes: start is only raised with den != 0; start while busy is ignored.
module ratio_divider
    import freq_ratio_pkg::*;
#(
    parameter int unsigned NUM_W  = 16,
    parameter int unsigned FRAC_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [NUM_W-1:0]                     num,
    input  logic [NUM_W-1:0]                     den,
    output logic                                 busy,
    output logic [quot_width(NUM_W, FRAC_W)-1:0] quot,
    output logic                                 quot_vld
);

    localparam int unsigned QW   = quot_width(NUM_W, FRAC_W);
    localparam int unsigned CW   = $clog2(QW + 1);
    localparam logic [CW-1:0] STEPS = CW'(QW);

    div_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [QW-1:0]   dvd_q;
    logic [NUM_W:0]  rem_q;
    logic [NUM_W-1:0] den_q;

    logic [NUM_W:0]  rem_sh;
    logic            fit;
    logic [NUM_W:0]  rem_nxt;
    logic [QW-1:0]   dvd_nxt;

    // One restoring step: shift in a dividend bit, trial-subtract.
    always_comb begin
        rem_sh  = {rem_q[NUM_W-1:0], dvd_q[QW-1]};
        fit     = (rem_sh >= {1'b0, den_q});
        rem_nxt = fit ? (rem_sh - {1'b0, den_q}) : rem_sh;
        dvd_nxt = {dvd_q[QW-2:0], fit};
    end

    assign busy = (state_q == DIV_RUN);

    // Sequence the division and publish the quotient on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DIV_IDLE;
            cnt_q    <= '0;
            dvd_q    <= '0;
            rem_q    <= '0;
            den_q    <= '0;
            quot     <= '0;
            quot_vld <= 1'b0;
        end else begin
            quot_vld <= 1'b0;
            if (state_q == DIV_IDLE) begin
                if (start) begin
                    state_q <= DIV_RUN;
                    cnt_q   <= STEPS;
                    dvd_q   <= {num, {FRAC_W{1'b0}}};
                    rem_q   <= '0;
                    den_q   <= den;
                end
            end else begin
                dvd_q <= dvd_nxt;
                rem_q <= rem_nxt;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    state_q  <= DIV_IDLE;
                    quot     <= dvd_nxt;
                    quot_vld <= 1'b1;
                end
            end
        end
    end

    // Partial remainder always stays below the divisor.
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q < {1'b0, den_q}));

    // Result strobe is a single cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        quot_vld |=> !quot_vld);

    // A running division never divides by zero.
    p_no_zero_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (den_q != '0));

    // A start seen while busy does not reload the step counter.
    p_drop_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/freq_ratio_calc.sv
// Module: freq_ratio_calc (top)
// Differentiates reference- and signal-clock phase streams, carries the
// signal count into the reference domain and divides the two counts to
// give f(sig)/f(ref) with FRAC_W fractional bits.
// Assumes: ref_clk and sig_clk are asynchronous; each reset is synchronous
// to its own clock; phase samples are single-cycle strobes.
module freq_ratio_calc
    import freq_ratio_pkg::*;
#(
    parameter int unsigned PHASE_W     = 16,
    parameter int unsigned FRAC_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       ref_clk,
    input  logic                       ref_rst_n,
    input  logic                       sig_clk,
    input  logic                       sig_rst_n,
    input  logic [PHASE_W-1:0]         ref_phase,
    input  logic                       ref_phase_vld,
    input  logic [PHASE_W-1:0]         sig_phase,
    input  logic                       sig_phase_vld,
    output logic [PHASE_W-1:0]         dref,
    output logic                       dref_vld,
    output logic [PHASE_W-1:0]         dsig,
    output logic                       dsig_sig_vld,
    output logic [PHASE_W-1:0]         dsig_ref,
    output logic                       dsig_have,
    output logic [PHASE_W+FRAC_W-1:0]  fout,
    output logic                       fout_vld
);

    logic dsig_ref_vld;
    logic div_busy;
    logic div_start;

    phase_delta #(.W(PHASE_W)) u_ref_delta (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .in_phase (ref_phase),
        .in_vld   (ref_phase_vld),
        .freq     (dref),
        .freq_vld (dref_vld)
    );

    phase_delta #(.W(PHASE_W)) u_sig_delta (
        .clk      (sig_clk),
        .rst_n    (sig_rst_n),
        .in_phase (sig_phase),
        .in_vld   (sig_phase_vld),
        .freq     (dsig),
        .freq_vld (dsig_sig_vld)
    );

    word_xfer #(.W(PHASE_W), .STAGES(SYNC_STAGES)) u_sig_to_ref (
        .src_clk   (sig_clk),
        .src_rst_n (sig_rst_n),
        .src_data  (dsig),
        .src_vld   (dsig_sig_vld),
        .dst_clk   (ref_clk),
        .dst_rst_n (ref_rst_n),
        .dst_data  (dsig_ref),
        .dst_vld   (dsig_ref_vld),
        .dst_have  (dsig_have)
    );

    // Launch a division for a fresh reference count when one can be accepted.
    always_comb begin
        div_start = dref_vld && !div_busy && dsig_have && (dsig_ref != '0);
    end

    ratio_divider #(.NUM_W(PHASE_W), .FRAC_W(FRAC_W)) u_div (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .start    (div_start),
        .num      (dref),
        .den      (dsig_ref),
        .busy     (div_busy),
        .quot     (fout),
        .quot_vld (fout_vld)
    );

    // A ratio is only ever published once a signal count has arrived.
    p_fout_needs_dsig_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        fout_vld |-> dsig_have);

    // Arrival flag never drops outside reset.
    p_have_sticky_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $past(dsig_have) |-> dsig_have);

    // Transfer strobe and arrival flag agree.
    p_xfer_sets_have_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        dsig_ref_vld |-> dsig_have);

endmodule

// File: tb/freq_ratio_calc_bench.sv
module freq_ratio_calc_bench;

    localparam int unsigned PW = 16;
    localparam int unsigned FW = 16;
    localparam int unsigned NW = PW + FW;

    logic ref_clk = 1'b0;
    logic sig_clk = 1'b0;
    logic ref_rst_n = 1'b0;
    logic sig_rst_n = 1'b0;
    logic [PW-1:0] rp = '0;
    logic          rv = 1'b0;
    logic [PW-1:0] sp = '0;
    logic          sv = 1'b0;

    logic [PW-1:0]    dref, dsig, dsig_ref;
    logic             dref_vld, dsig_sig_vld, dsig_have, fout_vld;
    logic [NW-1:0]    fout;

    always #2    ref_clk = ~ref_clk;   // 250 MHz
    always #2.65 sig_clk = ~sig_clk;

    freq_ratio_calc #(.PHASE_W(PW), .FRAC_W(FW), .SYNC_STAGES(2)) u_freq_ratio_calc (
        .ref_clk, .ref_rst_n, .sig_clk, .sig_rst_n,
        .ref_phase(rp), .ref_phase_vld(rv),
        .sig_phase(sp), .sig_phase_vld(sv),
        .dref, .dref_vld, .dsig, .dsig_sig_vld,
        .dsig_ref, .dsig_have, .fout, .fout_vld
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_pulse = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model state (REF domain).
    longint m_prev = 0, m_dref = 0, m_fout = 0, m_pend = 0;
    bit     m_primed = 0, m_dref_vld = 0, m_fout_vld = 0;
    int     m_cnt = 0;
    bit     m_have = 0;
    longint m_dsig = 0;

    // Advance the model on every REF edge and compare against the outputs.
    always @(posedge ref_clk) begin
        logic [PW-1:0] p_s;
        logic v_s, r_s;
        bit fv;
        p_s = rp; v_s = rv; r_s = ref_rst_n;
        #1;
        if (!r_s) begin
            m_prev = 0; m_dref = 0; m_fout = 0; m_pend = 0;
            m_primed = 0; m_dref_vld = 0; m_fout_vld = 0; m_cnt = 0;
            chk("R1 fout_vld", fout_vld, 0);
            chk("R1 dsig_have", dsig_have, 0);
        end else begin
            fv = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin m_fout = m_pend; fv = 1; end
            end else if (m_dref_vld && m_have && m_dsig != 0) begin
                m_cnt = NW;
                m_pend = (m_dref << FW) / m_dsig;
            end
            m_fout_vld = fv;
            m_dref_vld = 0;
            if (v_s) begin
                if (m_primed) begin
                    m_dref = (longint'(p_s) - m_prev) & ((64'd1 << PW) - 1);
                    m_dref_vld = 1;
                end
                m_prev = p_s; m_primed = 1;
            end
        end
        chk("R3 dref_vld", dref_vld, m_dref_vld);
        chk("R3 dref", dref, m_dref);
        chk("R6 fout_vld", fout_vld, m_fout_vld);
        chk("R6 fout", fout, m_fout);
        if (fout_vld) n_pulse++;
    end

    // SIG-side expectation.
    longint s_prev = 0;
    bit     s_primed = 0;

    task automatic ref_sample(input logic [PW-1:0] p);
        @(negedge ref_clk); rp = p; rv = 1'b1;
        @(negedge ref_clk); rv = 1'b0;
    endtask

    task automatic ref_idle(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic sig_sample(input logic [PW-1:0] p);
        longint e;
        @(negedge sig_clk); sp = p; sv = 1'b1;
        @(negedge sig_clk); sv = 1'b0;
        if (!s_primed) begin
            chk("R2 dsig_sig_vld first", dsig_sig_vld, 0);
        end else begin
            e = (longint'(p) - s_prev) & ((64'd1 << PW) - 1);
            chk("R4 dsig_sig_vld", dsig_sig_vld, 1);
            chk("R4 dsig", dsig, e);
        end
        s_prev = p; s_primed = 1;
    endtask

    task automatic settle_dsig(input longint e);
        ref_idle(30);
        chk("R5 dsig_have", dsig_have, 1);
        chk("R5 dsig_ref", dsig_ref, e);
        m_have = 1; m_dsig = e;
    endtask

    initial begin
        int base;
        repeat (6) @(negedge ref_clk);
        chk("R1 dref", dref, 0);
        chk("R1 fout", fout, 0);
        chk("R1 dsig_ref", dsig_ref, 0);
        ref_rst_n = 1'b1;
        @(negedge sig_clk); sig_rst_n = 1'b1;
        ref_idle(2);
        chk("R1 dref_vld after reset", dref_vld, 0);

        // Reference counts with no signal count yet.
        ref_sample(16'd1000);
        chk("R2 dref_vld first", dref_vld, 0);
        ref_sample(16'd1300);
        ref_idle(40);
        chk("R7 no dsig yet, pulses", n_pulse, 0);

        // Signal count 250.
        sig_sample(16'd5000);
        sig_sample(16'd5250);
        settle_dsig(250);

        // Basic ratio: 300/250.
        ref_sample(16'd1600);
        ref_idle(40);
        chk("R6 fout 300/250", fout, (longint'(300) << FW) / 250);

        // Back-to-back counts while busy: only the first is divided.
        base = n_pulse;
        @(negedge ref_clk); rp = 16'd1860; rv = 1'b1;
        @(negedge ref_clk); rp = 16'd2130;
        @(negedge ref_clk); rp = 16'd2410;
        @(negedge ref_clk); rv = 1'b0;
        ref_idle(45);
        chk("R8 one pulse for burst", n_pulse - base, 1);
        chk("R8 result of first", fout, (longint'(260) << FW) / 250);

        // Wraparound of the phase counter.
        ref_sample(16'd65500);
        ref_idle(40);
        ref_sample(16'd200);
        chk("R9 wrap dref", dref, 236);
        ref_idle(40);
        chk("R9 wrap fout", fout, (longint'(236) << FW) / 250);

        // Two signal counts quickly: newest wins.
        sig_sample(16'd5650);
        sig_sample(16'd6060);
        settle_dsig(410);

        // Equal counts give 1.0.
        ref_sample(16'd610);
        ref_idle(40);
        chk("R6 unity ratio", fout, longint'(1) << FW);

        // Zero signal count suppresses the output.
        sig_sample(16'd6060);
        settle_dsig(0);
        base = n_pulse;
        ref_sample(16'd900);
        ref_idle(40);
        chk("R7 zero dsig, pulses", n_pulse - base, 0);
        chk("R7 fout held", fout, longint'(1) << FW);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge ref_clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule